// File: doc/BRIEF.md
# Watchdog Timer with Dual-Clear Option

This block is a watchdog built from a prescaler with a selectable division ratio and an 8-bit timeout counter behind it. It advances only on a free-running low-frequency `tick` enable, sampled on the system clock. Software keeps the watchdog quiet with clear strobes. A static configuration input picks one of two clearing schemes. In single-command mode one strobe clears the watchdog. In two-command mode two distinct strobes must both arrive, in either order, before the clear takes effect.

When the timeout counter wraps, the block emits a one-cycle timeout pulse and sets a sticky timeout flag. It also reports which kind of reset the wrap asks for. A wrap while the device runs requests a full chip reset. A wrap while the device is halted requests a warm reset, in which only the program counter and the stack pointer are reset. The halt-entry strobe moves the block into its halted state and clears the count. The warm-reset wrap returns the block to the running state.

There are two small state machines. The power machine has the states `PW_RUN` and `PW_HALT`. It takes the transition *enter-halt* (`PW_RUN`→`PW_HALT` on `halt_enter`) and the transition *wake-on-timeout* (`PW_HALT`→`PW_RUN` on a wrap). The clear sequencer has the states `CQ_IDLE`, `CQ_GOT_A` and `CQ_GOT_B`. Its transitions are *arm-A* (`CQ_IDLE`→`CQ_GOT_A` on `clr_first` alone), *arm-B* (`CQ_IDLE`→`CQ_GOT_B` on `clr_second` alone), and *complete* (`CQ_GOT_A`→`CQ_IDLE` on `clr_second`, `CQ_GOT_B`→`CQ_IDLE` on `clr_first`, or `CQ_IDLE`→`CQ_IDLE` with both strobes in one cycle). A *complete* transition issues the clear.

Top module: `wdog_top`

## Requirements
- R1: `ratio_sel` sets the number of ticks per prescaler period, which is 128, 16, 32, 64, 1, 2, 4, 8 for the codes 0 through 7 in that order.
- R2: The timeout counter is 8 bits wide. The counter is cleared at the last clear. `timeout` is high for exactly one clock cycle, in the cycle after the clock edge that samples the tick completing the 256th prescaler period counted from that clear.
- R3: With `dual_mode` = 0, a single-cycle `clr_single` clears the counter and the prescaler. `clr_first` and `clr_second` have no effect in this mode.
- R4: With `dual_mode` = 1, the counter and the prescaler are cleared only once both `clr_first` and `clr_second` have been seen. They may come in either order or in the same cycle. `clr_single` has no effect in this mode.
- R5: In two-command mode, repeating the strobe that is already pending does not complete the clear. The pending strobe stays remembered until the clear completes or reset is asserted, and counting continues meanwhile.
- R6: `halt_enter` clears the counter and the prescaler and puts the block in the halted state. It has no effect on a pending two-command strobe.
- R7: A wrap in the running state gives a one-cycle `full_rst` together with `timeout` and sets `to_flag`.
- R8: A wrap in the halted state gives a one-cycle `warm_rst` together with `timeout`, sets `to_flag`, and returns the block to the running state.
- R9: `to_flag` stays set until `halt_enter` or reset clears it. It is cleared in the cycle after `halt_enter`.
- R10: A change of `ratio_sel` restarts the prescaler from zero. A tick in the cycle of the change is not counted. The timeout counter keeps its value.
- R11: Asserting `rst_n` low at once clears the counters, the pending clear, the halted state and all four outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External reset, asynchronous, active low |
| tick | input | 1 | Low-frequency count enable, one clock wide per tick |
| ratio_sel | input | 3 | Prescaler ratio code |
| dual_mode | input | 1 | Static option: 0 selects single-command clear, 1 selects two-command clear |
| clr_single | input | 1 | Clear strobe used in single-command mode |
| clr_first | input | 1 | One of the two clear strobes used in two-command mode |
| clr_second | input | 1 | The other clear strobe used in two-command mode |
| halt_enter | input | 1 | Halt-entry strobe |
| timeout | output | 1 | One-cycle pulse on counter wrap |
| full_rst | output | 1 | One-cycle request for a full chip reset |
| warm_rst | output | 1 | One-cycle request for a warm reset |
| to_flag | output | 1 | Sticky timeout status |

## Verification
Every one of the eight ratio codes is run through a complete timeout period, so a swapped entry in the non-monotonic code table shows up as a wrong pulse time. One code is run with a sparse tick to separate counting ticks from counting clocks. In two-command mode the strobes are sent in order A-B, B-A and together. Runs with only A repeated, and with only the single-command strobe, must still time out. Together these separate a correct two-key sequencer from one that accepts any strobe or a repeated key. Halt entry before a wrap must produce a warm request, and plain running must produce a full request. Ratio changes in mid-period and a reset in mid-count show whether partial periods and sticky state are dropped.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic {
        PW_RUN  = 1'b0,
        PW_HALT = 1'b1
    } pwr_state_e;

    typedef enum logic [1:0] {
        CQ_IDLE  = 2'd0,
        CQ_GOT_A = 2'd1,
        CQ_GOT_B = 2'd2
    } clr_state_e;

    localparam int SEL_W = 3;

    // log2 of the division ratio; codes 4..7 are the small ratios,
    // code 0 is the largest, codes 1..3 are the middle ones.
    function automatic logic [2:0] ratio_shift(input logic [SEL_W-1:0] sel);
        if (sel[2]) begin
            return {1'b0, sel[1:0]};
        end else if (sel[1:0] == 2'b00) begin
            return 3'd7;
        end else begin
            return {1'b0, sel[1:0]} + 3'd3;
        end
    endfunction

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int PRE_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       restart,
    input  logic [2:0] shift,
    output logic       period_end
);

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] limit;

    always_comb begin
        limit = PRE_W'((32'd1 << shift) - 32'd1);
    end

    assign period_end = tick && !restart && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == limit) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdog_timeout_ctr.sv
module wdog_timeout_ctr #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    output logic wrap
);

    logic [CNT_W-1:0] cnt_q;

    assign wrap = advance && !clear && (cnt_q == {CNT_W{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (advance) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_clear_seq.sv
module wdog_clear_seq
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dual_mode,
    input  logic clr_single,
    input  logic clr_first,
    input  logic clr_second,
    output logic kick
);

    clr_state_e st_q;
    clr_state_e st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CQ_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        kick = 1'b0;
        if (!dual_mode) begin
            kick = clr_single;
            st_d = CQ_IDLE;
        end else begin
            unique case (st_q)
                CQ_IDLE: begin
                    if (clr_first && clr_second) begin
                        kick = 1'b1;
                    end else if (clr_first) begin
                        st_d = CQ_GOT_A;
                    end else if (clr_second) begin
                        st_d = CQ_GOT_B;
                    end
                end
                CQ_GOT_A: begin
                    if (clr_second) begin
                        kick = 1'b1;
                        st_d = CQ_IDLE;
                    end
                end
                CQ_GOT_B: begin
                    if (clr_first) begin
                        kick = 1'b1;
                        st_d = CQ_IDLE;
                    end
                end
                default: begin
                    st_d = CQ_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int PRE_W = 7,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [SEL_W-1:0] ratio_sel,
    input  logic             dual_mode,
    input  logic             clr_single,
    input  logic             clr_first,
    input  logic             clr_second,
    input  logic             halt_enter,
    output logic             timeout,
    output logic             full_rst,
    output logic             warm_rst,
    output logic             to_flag
);

    logic [SEL_W-1:0] sel_q;
    logic             sel_changed;
    logic             kick;
    logic             clear_all;
    logic             period_end;
    logic             wrap;
    pwr_state_e       pwr_q;
    pwr_state_e       pwr_d;

    assign sel_changed = (ratio_sel != sel_q);
    assign clear_all   = kick || halt_enter;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= ratio_sel;
        end
    end

    wdog_clear_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .dual_mode  (dual_mode),
        .clr_single (clr_single),
        .clr_first  (clr_first),
        .clr_second (clr_second),
        .kick       (kick)
    );

    wdog_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .restart    (clear_all || sel_changed),
        .shift      (ratio_shift(ratio_sel)),
        .period_end (period_end)
    );

    wdog_timeout_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear_all),
        .advance (period_end),
        .wrap    (wrap)
    );

    // power state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_q <= PW_RUN;
        end else begin
            pwr_q <= pwr_d;
        end
    end

    always_comb begin
        pwr_d = pwr_q;
        unique case (pwr_q)
            PW_RUN:  if (halt_enter) pwr_d = PW_HALT;
            PW_HALT: if (wrap)       pwr_d = PW_RUN;
            default: pwr_d = PW_RUN;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timeout  <= 1'b0;
            full_rst <= 1'b0;
            warm_rst <= 1'b0;
            to_flag  <= 1'b0;
        end else begin
            timeout  <= wrap;
            full_rst <= wrap && (pwr_q == PW_RUN);
            warm_rst <= wrap && (pwr_q == PW_HALT);
            if (halt_enter) begin
                to_flag <= 1'b0;
            end else if (wrap) begin
                to_flag <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker (
    input logic clk,
    input logic rst_n,
    input logic dual_mode,
    input logic clr_single,
    input logic clr_first,
    input logic clr_second,
    input logic halt_enter,
    input logic timeout,
    input logic full_rst,
    input logic warm_rst,
    input logic to_flag
);

    a_r2_single_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);

    a_r7_one_reset_type: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (full_rst != warm_rst));

    a_r8_no_type_without_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (full_rst || warm_rst) |-> timeout);

    a_r7_flag_follows_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> to_flag);

    a_r6_halt_blocks_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        halt_enter |=> !timeout);

    a_r9_halt_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        halt_enter |=> !to_flag);

    a_r3_single_clear_blocks_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_mode && clr_single) |=> !timeout);

    a_r4_paired_clear_blocks_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_mode && clr_first && clr_second) |=> !timeout);

endmodule

bind wdog_top wdog_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dual_mode  (dual_mode),
    .clr_single (clr_single),
    .clr_first  (clr_first),
    .clr_second (clr_second),
    .halt_enter (halt_enter),
    .timeout    (timeout),
    .full_rst   (full_rst),
    .warm_rst   (warm_rst),
    .to_flag    (to_flag)
);

// File: tb/wdog_top_bench.sv
`timescale 1ns/1ps
module wdog_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [2:0] ratio_sel = 3'd4;
    logic       dual_mode = 1'b0;
    logic       clr_single = 1'b0;
    logic       clr_first = 1'b0;
    logic       clr_second = 1'b0;
    logic       halt_enter = 1'b0;
    logic       timeout, full_rst, warm_rst, to_flag;

    int    vectors = 0;
    int    errors = 0;
    int    cyc = 0;
    int    tick_div = 1;
    int    tick_ph = 0;
    string cur_req = "R11";

    always #10 clk = ~clk;

    wdog_top u_wdog_top (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ratio_sel(ratio_sel),
        .dual_mode(dual_mode), .clr_single(clr_single), .clr_first(clr_first),
        .clr_second(clr_second), .halt_enter(halt_enter), .timeout(timeout),
        .full_rst(full_rst), .warm_rst(warm_rst), .to_flag(to_flag)
    );

    // ---------------- behavioural reference ----------------
    int m_pre, m_cnt, m_selq, m_pend, m_halt;
    bit m_to, m_full, m_warm, m_flag;

    function automatic int ticks_per_period(input int code);
        case (code)
            0: return 128;
            1: return 16;
            2: return 32;
            3: return 64;
            4: return 1;
            5: return 2;
            6: return 4;
            default: return 8;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_selq = 0; m_pend = 0; m_halt = 0;
            m_to = 0; m_full = 0; m_warm = 0; m_flag = 0;
        end else begin
            bit done, clr, pout, ovf;
            done = 0;
            if (dual_mode)
                done = (clr_first && clr_second) || (m_pend == 1 && clr_second)
                       || (m_pend == 2 && clr_first);
            clr = (dual_mode ? done : clr_single) || halt_enter;
            pout = 0;
            if (clr || ratio_sel != m_selq) m_pre = 0;
            else if (tick) begin
                if (m_pre == ticks_per_period(ratio_sel) - 1) begin m_pre = 0; pout = 1; end
                else m_pre++;
            end
            ovf = 0;
            if (clr) m_cnt = 0;
            else if (pout) begin
                if (m_cnt == 255) begin m_cnt = 0; ovf = 1; end
                else m_cnt++;
            end
            if (!dual_mode || done) m_pend = 0;
            else if (m_pend == 0) m_pend = clr_first ? 1 : (clr_second ? 2 : 0);
            m_to = ovf;
            m_full = ovf && m_halt == 0;
            m_warm = ovf && m_halt == 1;
            if (halt_enter) m_flag = 0;
            else if (ovf) m_flag = 1;
            if (halt_enter) m_halt = 1;
            else if (ovf) m_halt = 0;
            m_selq = ratio_sel;
        end
    end

    // ---------------- compare on every clock ----------------
    always @(negedge clk) begin
        vectors++;
        if ({timeout, full_rst, warm_rst, to_flag} !== {m_to, m_full, m_warm, m_flag}) begin
            errors++;
            $display("FAIL %s cycle %0d: got to/full/warm/flag=%b expected %b", cur_req, cyc,
                     {timeout, full_rst, warm_rst, to_flag}, {m_to, m_full, m_warm, m_flag});
        end
    end

    always @(negedge clk) begin
        tick_ph = (tick_ph + 1) % tick_div;
        tick = (tick_ph == 0);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog expired (all of R1..R11 unfinished), got running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // 0 single, 1 first, 2 second, 3 both, 4 halt
    task automatic strobe(input int which);
        @(negedge clk);
        clr_single = (which == 0);
        clr_first  = (which == 1 || which == 3);
        clr_second = (which == 2 || which == 3);
        halt_enter = (which == 4);
        @(negedge clk);
        clr_single = 0; clr_first = 0; clr_second = 0; halt_enter = 0;
    endtask

    task automatic do_reset(input bit dual);
        @(posedge clk); #2 rst_n = 0;
        wait_cycles(3);
        dual_mode = dual;
        @(posedge clk); #2 rst_n = 1;
    endtask

    initial begin
        // R11: reset state
        cur_req = "R11";
        wait_cycles(3);
        @(posedge clk); #2 rst_n = 1;

        // R1 / R2 / R7 / R10: every ratio code through a full timeout
        for (int i = 0; i < 8; i++) begin
            int code;
            code = (i + 4) % 8;
            cur_req = (i == 0) ? "R2" : "R1";
            @(negedge clk); ratio_sel = code[2:0];
            tick_div = (code == 5) ? 3 : 1;
            wait_cycles(256 * ticks_per_period(code) * tick_div + 6);
        end
        cur_req = "R7";
        wait_cycles(4);

        // R10: ratio change mid-period
        cur_req = "R10";
        tick_div = 1;
        @(negedge clk); ratio_sel = 3'd6;
        wait_cycles(401);
        @(negedge clk); ratio_sel = 3'd7;
        wait_cycles(3);
        @(negedge clk); ratio_sel = 3'd6;
        wait_cycles(1200);

        // R3: single-command clear, paired strobes ignored
        cur_req = "R3";
        @(negedge clk); ratio_sel = 3'd4;
        for (int k = 0; k < 6; k++) begin
            wait_cycles(150);
            strobe(0);
        end
        strobe(1); strobe(2); strobe(3);
        wait_cycles(300);

        // R6 / R8: halt then wrap gives warm reset
        cur_req = "R6";
        strobe(4);
        wait_cycles(100);
        cur_req = "R8";
        wait_cycles(200);
        // R9: flag cleared by halt entry
        cur_req = "R9";
        strobe(4);
        wait_cycles(5);
        strobe(4);
        wait_cycles(300);
        // R7: running wrap gives full reset
        cur_req = "R7";
        wait_cycles(300);

        // sparse ticks
        cur_req = "R2";
        tick_div = 5;
        wait_cycles(1300);
        tick_div = 1;

        // R4: two-command mode
        do_reset(1'b1);
        cur_req = "R4";
        for (int k = 0; k < 3; k++) begin
            wait_cycles(100); strobe(1); wait_cycles(20); strobe(2);
        end
        for (int k = 0; k < 3; k++) begin
            wait_cycles(100); strobe(2); wait_cycles(20); strobe(1);
        end
        for (int k = 0; k < 3; k++) begin
            wait_cycles(200); strobe(3);
        end
        for (int k = 0; k < 4; k++) begin
            wait_cycles(100); strobe(0);
        end
        wait_cycles(100);

        // R5: repeated same strobe does not complete
        cur_req = "R5";
        strobe(2);
        for (int k = 0; k < 7; k++) begin
            wait_cycles(80); strobe(1);
        end
        wait_cycles(100);
        strobe(2);
        for (int k = 0; k < 4; k++) begin
            wait_cycles(120); strobe(2);
        end
        wait_cycles(60);
        strobe(1);
        wait_cycles(300);

        // R11: reset mid-count
        cur_req = "R11";
        wait_cycles(120);
        do_reset(1'b0);
        wait_cycles(300);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule